// File: doc/BRIEF.md
# UART Interrupt Priority and Timeout Unit

This block sits next to the register file of a serial controller that has 16-byte receive and transmit FIFOs. It gathers every interrupt condition of the controller and presents the one with the highest priority as a 4-bit identification code, together with an active-high interrupt line. The character datapath and the FIFO storage are outside the block. It sees only the receive FIFO fill level, a two-bit trigger select, a line-error event pulse, the transmit-empty flag, the modem delta summary, four enable bits, and one-cycle strobes that mark register accesses.

The receive timeout is a three-state machine. In `TO_IDLE` the timer is not running. `TO_IDLE -> TO_COUNT` is taken when the FIFO holds data below the trigger level. In `TO_COUNT` the timer counts baud ticks and restarts on every push or pop. `TO_COUNT -> TO_IDLE` is taken when the FIFO leaves the armed window. `TO_COUNT -> TO_FIRED` is taken on the tick that completes four character times. `TO_FIRED` holds the timeout pending. `TO_FIRED -> TO_COUNT` or `TO_FIRED -> TO_IDLE` is taken on a receive read or an empty FIFO, and the choice depends on whether the window is still armed. A character time is the frame length in bits, counted in baud ticks.

Top module: `uart_irq_unit`

## Requirements
- R1: Pending, enabled sources are reported in the order line status (0110) > receive timeout (1100) > receive data (0100) > transmit empty (0010) > modem status (0000). Only the highest one appears on `irq_id`.
- R2: Receive data is pending while `rx_level` is at least the trigger level. `trig_sel` selects the level: 00=1, 01=4, 10=8, 11=14 bytes.
- R3: While 0 < `rx_level` < trigger, the timeout becomes pending after 4×`frame_bits` baud ticks with no `rx_push` or `rx_pop`. Any push or pop restarts the count. The code is visible the cycle after the final tick.
- R4: A pending timeout clears on `rx_pop` or when `rx_level` is 0. Line status reads and identification reads leave it pending.
- R5: An `err_evt` pulse latches line status pending. It stays pending until `lsr_rd`. If both occur in the same cycle, the set wins.
- R6: Transmit empty becomes pending on a rising `thr_empty`, or on a rising `ien[1]` while `thr_empty` is high. It clears on `thr_wr`, or on `iir_rd` in a cycle where `irq_id` reports 0010.
- R7: An `iir_rd` in a cycle where `irq_id` shows a different code leaves transmit empty pending.
- R8: Modem status is pending exactly while `msr_delta` is high.
- R9: The enable bits are `ien[0]` receive data and timeout, `ien[1]` transmit empty, `ien[2]` line status, `ien[3]` modem. `irq` is the OR of all enabled pending sources. `irq_id` is 0001 (bit 0 set) when none is enabled and pending, and disabled sources stay invisible.
- R10: After reset, `irq_id` is 0001 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_level | input | 5 | Receive FIFO fill level, 0..16 |
| trig_sel | input | 2 | Receive trigger select |
| frame_bits | input | 4 | Bits per serial frame (7..12) |
| baud_tick | input | 1 | One pulse per bit time |
| rx_push | input | 1 | A character entered the receive FIFO |
| rx_pop | input | 1 | Receive data register read |
| err_evt | input | 1 | Line error detected |
| lsr_rd | input | 1 | Line status register read |
| thr_empty | input | 1 | Transmit holding side empty |
| thr_wr | input | 1 | Transmit data register write |
| iir_rd | input | 1 | Identification register read |
| msr_delta | input | 1 | Any modem status delta bit set |
| ien | input | 4 | Interrupt enables |
| irq_id | output | 4 | Identification code |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following. The interrupt line agrees with the identification code. Line status outranks everything else once it is enabled. A timeout only appears right after an undisturbed baud tick and persists until a receive read or an empty FIFO. The line-status and transmit-empty latches hold or clear only on their own strobes. The exact tick on which the timeout fires, the restart on push, the trigger-level mapping, and the clearing of transmit empty through an identification read that does or does not report it can only be shown by the bench's scenarios against its reference model.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } to_state_e;

    localparam logic [3:0] ID_NONE = 4'b0001;
    localparam logic [3:0] ID_LS   = 4'b0110;
    localparam logic [3:0] ID_TO   = 4'b1100;
    localparam logic [3:0] ID_RX   = 4'b0100;
    localparam logic [3:0] ID_TX   = 4'b0010;
    localparam logic [3:0] ID_MS   = 4'b0000;

    // source index order equals priority order, 0 is highest
    localparam int NSRC = 5;

    function automatic int unsigned trig_bytes(input logic [1:0] sel);
        unique case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [3:0] src_code(input int idx);
        unique case (idx)
            0:       return ID_LS;
            1:       return ID_TO;
            2:       return ID_RX;
            3:       return ID_TX;
            default: return ID_MS;
        endcase
    endfunction

endpackage

// File: rtl/uirq_timeout.sv
module uirq_timeout
    import uirq_pkg::*;
#(
    parameter int FRAME_W  = 4,
    parameter int TO_CHARS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               armed,
    input  logic               has_data,
    input  logic               rx_push,
    input  logic               rx_pop,
    input  logic               baud_tick,
    input  logic [FRAME_W-1:0] frame_bits,
    output logic               fired
);
    localparam int CNT_W = FRAME_W + $clog2(TO_CHARS) + 1;

    to_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(TO_CHARS) * CNT_W'(frame_bits);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TO_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TO_IDLE: begin
                if (armed) begin
                    state_d = TO_COUNT;
                    cnt_d   = '0;
                end
            end
            TO_COUNT: begin
                if (!armed) begin
                    state_d = TO_IDLE;
                end else if (rx_push || rx_pop) begin
                    cnt_d = '0;
                end else if (baud_tick) begin
                    if (cnt_q == limit - 1'b1) begin
                        state_d = TO_FIRED;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            TO_FIRED: begin
                if (rx_pop || !has_data) begin
                    state_d = armed ? TO_COUNT : TO_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = TO_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        fired = (state_q == TO_FIRED);
    end

    a_r3_fire_after_quiet_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fired) |-> ($past(baud_tick) && !$past(rx_push) && !$past(rx_pop)));

    a_r4_fired_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && !rx_pop && has_data) |=> fired);

    a_r3_unarmed_stays_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !fired) |=> !fired);

endmodule

// File: rtl/uirq_sources.sv
module uirq_sources
    import uirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       err_evt,
    input  logic       lsr_rd,
    input  logic       thr_empty,
    input  logic       thr_en,
    input  logic       thr_wr,
    input  logic       iir_rd,
    input  logic [3:0] id_now,
    output logic       ls_pend,
    output logic       thre_pend
);
    logic empty_q;
    logic en_q;
    logic thre_set;
    logic thre_clr;

    assign thre_set = (thr_empty && !empty_q) || (thr_en && !en_q && thr_empty);
    assign thre_clr = thr_wr || (iir_rd && (id_now == ID_TX));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls_pend   <= 1'b0;
            thre_pend <= 1'b0;
            empty_q   <= 1'b1;
            en_q      <= 1'b0;
        end else begin
            empty_q <= thr_empty;
            en_q    <= thr_en;
            if (err_evt) begin
                ls_pend <= 1'b1;
            end else if (lsr_rd) begin
                ls_pend <= 1'b0;
            end
            if (thre_set) begin
                thre_pend <= 1'b1;
            end else if (thre_clr) begin
                thre_pend <= 1'b0;
            end
        end
    end

    a_r5_ls_holds_until_read: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_pend && !lsr_rd) |=> ls_pend);

    a_r5_ls_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> ls_pend);

    a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !thr_empty) |=> !thre_pend);

    a_r7_other_id_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (thre_pend && iir_rd && (id_now != ID_TX) && !thr_wr) |=> thre_pend);

endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  logic [NSRC-1:0] pend_en,
    output logic [3:0]      id
);
    always_comb begin
        id = ID_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_en[i]) begin
                id = src_code(i);
            end
        end
    end
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
    import uirq_pkg::*;
#(
    parameter  int FIFO_DEPTH = 16,
    parameter  int FRAME_W    = 4,
    parameter  int TO_CHARS   = 4,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic [1:0]         trig_sel,
    input  logic [FRAME_W-1:0] frame_bits,
    input  logic               baud_tick,
    input  logic               rx_push,
    input  logic               rx_pop,
    input  logic               err_evt,
    input  logic               lsr_rd,
    input  logic               thr_empty,
    input  logic               thr_wr,
    input  logic               iir_rd,
    input  logic               msr_delta,
    input  logic [3:0]         ien,
    output logic [3:0]         irq_id,
    output logic               irq
);
    logic [LVL_W-1:0] trig;
    logic             has_data;
    logic             rx_full;
    logic             armed;
    logic             to_fired;
    logic             ls_pend;
    logic             thre_pend;
    logic [NSRC-1:0]  pend_en;

    assign trig     = LVL_W'(trig_bytes(trig_sel));
    assign has_data = (rx_level != '0);
    assign rx_full  = (rx_level >= trig);
    assign armed    = has_data && !rx_full;

    uirq_timeout #(
        .FRAME_W  (FRAME_W),
        .TO_CHARS (TO_CHARS)
    ) u_timeout (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed      (armed),
        .has_data   (has_data),
        .rx_push    (rx_push),
        .rx_pop     (rx_pop),
        .baud_tick  (baud_tick),
        .frame_bits (frame_bits),
        .fired      (to_fired)
    );

    uirq_sources u_sources (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_evt   (err_evt),
        .lsr_rd    (lsr_rd),
        .thr_empty (thr_empty),
        .thr_en    (ien[1]),
        .thr_wr    (thr_wr),
        .iir_rd    (iir_rd),
        .id_now    (irq_id),
        .ls_pend   (ls_pend),
        .thre_pend (thre_pend)
    );

    assign pend_en[0] = ls_pend   && ien[2];
    assign pend_en[1] = to_fired  && ien[0];
    assign pend_en[2] = rx_full   && ien[0];
    assign pend_en[3] = thre_pend && ien[1];
    assign pend_en[4] = msr_delta && ien[3];

    uirq_prio u_prio (
        .pend_en (pend_en),
        .id      (irq_id)
    );

    assign irq = |pend_en;

    a_r9_line_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (irq_id != ID_NONE));

    a_r1_line_status_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_pend && ien[2]) |-> (irq_id == ID_LS));

    a_r9_all_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 4'b0000) |-> (!irq && irq_id == ID_NONE));

    a_r10_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq_id == ID_NONE));

endmodule

// File: tb/uart_irq_unit_bench.sv
module uart_irq_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] rx_level;
    logic [1:0] trig_sel;
    logic [3:0] frame_bits;
    logic       baud_tick, rx_push, rx_pop, err_evt, lsr_rd;
    logic       thr_empty, thr_wr, iir_rd, msr_delta;
    logic [3:0] ien;
    logic [3:0] irq_id;
    logic       irq;

    int n_vec  = 0;
    int n_fail = 0;

    // reference model state
    int m_st;    // 0 idle, 1 counting, 2 fired
    int m_cnt;
    bit m_ls, m_thre, m_pe, m_pen;

    always #10 clk = ~clk;

    uart_irq_unit u_uart_irq_unit (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .trig_sel(trig_sel),
        .frame_bits(frame_bits), .baud_tick(baud_tick), .rx_push(rx_push),
        .rx_pop(rx_pop), .err_evt(err_evt), .lsr_rd(lsr_rd), .thr_empty(thr_empty),
        .thr_wr(thr_wr), .iir_rd(iir_rd), .msr_delta(msr_delta), .ien(ien),
        .irq_id(irq_id), .irq(irq)
    );

    function automatic int trig_of(input logic [1:0] s);
        case (s)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [3:0] exp_id();
        int lvl = int'(rx_level);
        if (ien[2] && m_ls)                         return 4'b0110;
        if (ien[0] && m_st == 2)                    return 4'b1100;
        if (ien[0] && lvl >= trig_of(trig_sel))     return 4'b0100;
        if (ien[1] && m_thre)                       return 4'b0010;
        if (ien[3] && msr_delta)                    return 4'b0000;
        return 4'b0001;
    endfunction

    task automatic model_update();
        int  lvl   = int'(rx_level);
        bit  armed = (lvl > 0) && (lvl < trig_of(trig_sel));
        bit  set_t, clr_t;
        logic [3:0] cur = exp_id();
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_ls = 0; m_thre = 0; m_pe = 1; m_pen = 0;
            return;
        end
        case (m_st)
            0: if (armed) begin m_st = 1; m_cnt = 0; end
            1: begin
                if (!armed) m_st = 0;
                else if (rx_push || rx_pop) m_cnt = 0;
                else if (baud_tick) begin
                    if (m_cnt == 4 * int'(frame_bits) - 1) m_st = 2;
                    else m_cnt++;
                end
            end
            default: if (rx_pop || lvl == 0) begin m_st = armed ? 1 : 0; m_cnt = 0; end
        endcase
        set_t = (thr_empty && !m_pe) || (ien[1] && !m_pen && thr_empty);
        clr_t = thr_wr || (iir_rd && cur == 4'b0010);
        if (set_t) m_thre = 1; else if (clr_t) m_thre = 0;
        if (err_evt) m_ls = 1; else if (lsr_rd) m_ls = 0;
        m_pe  = thr_empty;
        m_pen = ien[1];
    endtask

    // compare away from the edge, then advance one clock
    task automatic step(input string tag);
        logic [3:0] e_id;
        #1;
        e_id = rst_n ? exp_id() : 4'b0001;
        n_vec++;
        if (irq_id !== e_id || irq !== (e_id != 4'b0001)) begin
            n_fail++;
            $display("FAIL %s: id=%b irq=%b expected id=%b irq=%b at %0t",
                     tag, irq_id, irq, e_id, (e_id != 4'b0001), $time);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run still active, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; rx_level = 0; trig_sel = 0; frame_bits = 4'd10;
        baud_tick = 0; rx_push = 0; rx_pop = 0; err_evt = 0; lsr_rd = 0;
        thr_empty = 1; thr_wr = 0; iir_rd = 0; msr_delta = 0; ien = 0;
        m_st = 0; m_cnt = 0; m_ls = 0; m_thre = 0; m_pe = 1; m_pen = 0;
        @(negedge clk);
        repeat (3) step("R10 reset");
        rst_n = 1;
        repeat (2) step("R10 after reset");

        // R2 trigger levels
        ien = 4'b0001; trig_sel = 2'b01; rx_level = 3; step("R2 below 4");
        rx_level = 4; step("R2 at 4"); step("R2 at 4");
        trig_sel = 2'b11; rx_level = 13; step("R2 below 14");
        rx_level = 14; step("R2 at 14");
        trig_sel = 2'b10; rx_level = 8; step("R2 at 8");
        trig_sel = 2'b00; rx_level = 1; step("R2 at 1");

        // R3 timeout with restart on push
        rx_level = 0; step("R3 empty");
        trig_sel = 2'b01; rx_level = 2; rx_push = 1; step("R3 push");
        rx_push = 0; baud_tick = 1;
        repeat (20) step("R3 counting");
        rx_level = 3; rx_push = 1; step("R3 restart");
        rx_push = 0;
        repeat (45) step("R3 to fire");
        baud_tick = 0;

        // R4 clearing rules, R1 priority over timeout
        lsr_rd = 1; step("R4 lsr read keeps");
        lsr_rd = 0; iir_rd = 1; step("R4 id read keeps");
        iir_rd = 0; ien = 4'b0101; err_evt = 1; step("R1 error event");
        err_evt = 0; step("R1 line status over timeout");
        lsr_rd = 1; step("R5 lsr read");
        lsr_rd = 0; step("R4 timeout back");
        rx_level = 2; rx_pop = 1; step("R4 pop");
        rx_pop = 0; step("R4 cleared");
        rx_level = 0; step("R4 empty");

        // R6 transmit empty
        ien = 4'b0010; thr_empty = 0; step("R6 busy");
        thr_empty = 1; step("R6 rise"); step("R6 pending");
        iir_rd = 1; step("R6 id read");
        iir_rd = 0; step("R6 cleared by read");
        thr_empty = 0; step("R6 busy2");
        thr_empty = 1; step("R6 rise2");
        thr_wr = 1; thr_empty = 0; step("R6 write");
        thr_wr = 0; step("R6 cleared by write");
        thr_empty = 1; ien = 4'b0000; step("R6 disabled empty");
        ien = 4'b0010; step("R6 enable rise"); step("R6 enable pending");

        // R7 id read reporting a different source
        ien = 4'b0110; err_evt = 1; step("R7 error");
        err_evt = 0; iir_rd = 1; step("R7 read shows line status");
        iir_rd = 0; step("R7 after read");
        lsr_rd = 1; step("R7 clear line status");
        lsr_rd = 0; step("R7 tx still pending");

        // R8 modem
        ien = 4'b1000; msr_delta = 1; step("R8 delta");
        msr_delta = 0; step("R8 no delta");

        // R9 masking
        ien = 4'b0000; err_evt = 1; msr_delta = 1; rx_level = 16; step("R9 masked");
        err_evt = 0; step("R9 masked"); step("R9 masked");
        ien = 4'b1111; step("R9 enabled"); step("R1 ls first");
        lsr_rd = 1; step("R1 ls read");
        lsr_rd = 0; step("R1 rx data next");
        rx_level = 0; step("R1 tx next");
        thr_wr = 1; thr_empty = 0; step("R1 tx write");
        thr_wr = 0; step("R1 modem last");
        msr_delta = 0; step("R9 idle");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule